// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block turns the system clock into time quanta through a programmable prescaler and steps every nominal bit through three segments: a one-quantum synchronization segment, a first phase segment and a second phase segment. The receive line is looked at once per quantum. A recessive-to-dominant transition found there either restarts the bit, when the bus is free, or moves the bit boundary by a bounded amount while a frame is in progress.

At the end of the first phase segment the block produces a one-clock sample strobe together with the sampled bit. The sampled bit is either the line level in the sample-point quantum or a two-of-three vote over the last three quanta. A one-clock transmit-point strobe marks the start of each synchronization segment. Frame decoding and bit stuffing live in a neighbouring block that consumes these strobes.

Top module: `can_bit_timing`

## Requirements
- R1: One time quantum lasts `presc_i`+1 clocks. With no falling edge on the line, transmit-point strobes repeat every (TSEG1+TSEG2+3)×(`presc_i`+1) clocks.
- R2: `cfg_i` is packed with the triple-sample flag in bit 7, TSEG2 in bits 6:4 and TSEG1 in bits 3:0. The sync segment lasts 1 quantum, the first phase segment TSEG1+1 quanta and the second phase segment TSEG2+1 quanta.
- R3: `sample_o` is a one-clock pulse at the end of the first phase segment. With no edges it rises (TSEG1+2)×(`presc_i`+1) clocks after a transmit-point strobe.
- R4: `txpt_o` is a one-clock pulse on entry to the sync segment, and it is never high in the same cycle as `sample_o`.
- R5: After reset `bit_o` is 1 (recessive) and both strobes are 0. `bit_o` changes only in a cycle where `sample_o` is high.
- R6: With bit 7 of `cfg_i` at 0, `bit_o` takes the line level seen at the end of the sample-point quantum.
- R7: With bit 7 of `cfg_i` at 1, `bit_o` takes the majority of the line levels seen at the ends of the last three quanta up to and including the sample-point quantum.
- R8: A falling edge is the line at 1 at one quantum end and at 0 at the next. With `bus_idle_i` high, a falling edge makes its own quantum the sync segment, so the sample strobe follows TSEG1+1 quanta later.
- R9: With `bus_idle_i` low, a falling edge in the first phase segment lengthens that segment by the smaller of its phase error and SJW+1 quanta. The phase error counts the quanta from the end of the sync segment up to and including the edge quantum.
- R10: With `bus_idle_i` low, a falling edge in the second phase segment has a phase error equal to the quanta from the edge quantum to the end of that segment, inclusive. If this is at most SJW+1, the edge quantum becomes the sync segment and the first phase segment starts next, with no transmit-point strobe. Otherwise the second phase segment is cut by SJW+1 quanta.
- R11: An edge in the sync segment changes no timing. Only the first edge in a bit time may synchronize, and edges are ignored while `bit_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_i | input | 1 | Receive line, 1 = recessive |
| bus_idle_i | input | 1 | High while the bus is free; selects hard synchronization |
| presc_i | input | BRP_W (6) | Quantum length minus one, in clocks |
| cfg_i | input | TS1_W+TS2_W+1 (8) | {triple-sample flag, TSEG2, TSEG1} |
| sjw_i | input | SJW_W (2) | Jump width minus one, in quanta |
| bit_o | output | 1 | Sampled bit value |
| sample_o | output | 1 | One-clock sample-point strobe |
| txpt_o | output | 1 | One-clock strobe at sync segment start |

## Verification
The assertions make no assumption about the receive line or the idle flag. The strobe properties rest on every segment lasting at least one quantum, and that holds for any setting of the fields. Segment ends are compared with greater-or-equal, so a configuration change in the middle of a bit shortens that bit but does not break the single-pulse properties. The stimulus changes `presc_i` and `cfg_i` only between measurements and lets several bits pass before it measures. It moves the line once per quantum at most, and always in the second clock of a quantum, so every edge falls in a known quantum.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_ONE  = 2'd1,
    SEG_TWO  = 2'd2
  } seg_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int BRP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRP_W-1:0] presc_i,
  output logic             tick_o
);

  logic [BRP_W-1:0] cnt_q, cnt_d;

  // last clock of a quantum; >= keeps a shrunk setting from wrapping
  assign tick_o = (cnt_q >= presc_i);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (tick_o) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/can_bt_sampler.sv
module can_bt_sampler
  import can_bt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic rx_i,
  input  logic triple_i,
  input  logic take_i,
  output logic fall_o,
  output logic bit_o
);

  // hist_q[0]: line at the previous quantum end, hist_q[1]: the one before
  logic [1:0] hist_q, hist_d;
  logic       bit_q, bit_d, vote;

  assign fall_o = tick_i & hist_q[0] & ~rx_i;
  assign vote   = triple_i ? maj3(rx_i, hist_q[0], hist_q[1]) : rx_i;

  always_comb begin
    hist_d = hist_q;
    bit_d  = bit_q;
    if (tick_i) hist_d = {hist_q[0], rx_i};
    if (take_i) bit_d  = vote;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= 2'b11;
      bit_q  <= 1'b1;
    end else begin
      hist_q <= hist_d;
      bit_q  <= bit_d;
    end
  end

  assign bit_o = bit_q;

endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
#(
  parameter int TS1_W = 4,
  parameter int TS2_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             fall_i,
  input  logic             idle_i,
  input  logic             bit_i,
  input  logic [TS1_W-1:0] tseg1_i,
  input  logic [TS2_W-1:0] tseg2_i,
  input  logic [SJW_W-1:0] sjw_i,
  output logic             take_o,
  output logic             sample_o,
  output logic             txpt_o
);

  localparam int QC_W = TS1_W + SJW_W;
  localparam int EW   = QC_W + 1;

  seg_e            seg_q, seg_d;
  logic [QC_W-1:0] qc_q, qc_d;
  logic [EW-1:0]   ext_q, ext_d, short_q, short_d;
  logic            done_q, done_d;
  logic            smp_q, smp_d, txp_q, txp_d;

  logic            edge_ok, hard, resync;
  logic [EW-1:0]   jump, err_late, err_early, ext_n, short_n;

  assign edge_ok   = fall_i & bit_i & ~done_q;
  assign hard      = edge_ok & idle_i;
  assign resync    = edge_ok & ~idle_i;
  assign jump      = EW'(sjw_i) + 1'b1;
  assign err_late  = EW'(qc_q) + 1'b1;
  assign err_early = EW'(tseg2_i) + 1'b1 - EW'(qc_q);

  always_comb begin
    seg_d   = seg_q;
    qc_d    = qc_q;
    ext_d   = ext_q;
    short_d = short_q;
    done_d  = done_q;
    smp_d   = 1'b0;
    txp_d   = 1'b0;
    take_o  = 1'b0;
    ext_n   = ext_q;
    short_n = short_q;
    if (tick_i) begin
      if (hard) begin
        seg_d   = SEG_ONE;
        qc_d    = '0;
        ext_d   = '0;
        short_d = '0;
        done_d  = 1'b1;
      end else begin
        case (seg_q)
          SEG_SYNC: begin
            if (resync) done_d = 1'b1;
            seg_d = SEG_ONE;
            qc_d  = '0;
          end
          SEG_ONE: begin
            if (resync) begin
              done_d = 1'b1;
              ext_n  = (err_late < jump) ? err_late : jump;
            end
            ext_d = ext_n;
            if (EW'(qc_q) >= EW'(tseg1_i) + ext_n) begin
              seg_d  = SEG_TWO;
              qc_d   = '0;
              smp_d  = 1'b1;
              take_o = 1'b1;
            end else begin
              qc_d = qc_q + 1'b1;
            end
          end
          default: begin
            if (resync && (err_early <= jump)) begin
              seg_d   = SEG_ONE;
              qc_d    = '0;
              ext_d   = '0;
              short_d = '0;
              done_d  = 1'b1;
            end else begin
              if (resync) begin
                done_d  = 1'b1;
                short_n = jump;
              end
              short_d = short_n;
              if (EW'(qc_q) + short_n >= EW'(tseg2_i)) begin
                seg_d   = SEG_SYNC;
                qc_d    = '0;
                ext_d   = '0;
                short_d = '0;
                done_d  = 1'b0;
                txp_d   = 1'b1;
              end else begin
                qc_d = qc_q + 1'b1;
              end
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q   <= SEG_SYNC;
      qc_q    <= '0;
      ext_q   <= '0;
      short_q <= '0;
      done_q  <= 1'b0;
      smp_q   <= 1'b0;
      txp_q   <= 1'b0;
    end else begin
      seg_q   <= seg_d;
      qc_q    <= qc_d;
      ext_q   <= ext_d;
      short_q <= short_d;
      done_q  <= done_d;
      smp_q   <= smp_d;
      txp_q   <= txp_d;
    end
  end

  assign sample_o = smp_q;
  assign txpt_o   = txp_q;

endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing #(
  parameter int BRP_W = 6,
  parameter int TS1_W = 4,
  parameter int TS2_W = 3,
  parameter int SJW_W = 2,
  localparam int CFG_W = TS1_W + TS2_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic             bus_idle_i,
  input  logic [BRP_W-1:0] presc_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic [SJW_W-1:0] sjw_i,
  output logic             bit_o,
  output logic             sample_o,
  output logic             txpt_o
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             tick, fall, take, bit_val;
  logic [TS1_W-1:0] tseg1;
  logic [TS2_W-1:0] tseg2;
  logic             triple;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign tseg1  = cfg_i[TS1_W-1:0];
  assign tseg2  = cfg_i[TS1_W +: TS2_W];
  assign triple = cfg_i[CFG_W-1];

  can_bt_prescaler #(.BRP_W(BRP_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .presc_i (presc_i),
    .tick_o  (tick)
  );

  can_bt_sampler u_smp (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tick_i   (tick),
    .rx_i     (rx_i),
    .triple_i (triple),
    .take_i   (take),
    .fall_o   (fall),
    .bit_o    (bit_val)
  );

  can_bt_seq #(.TS1_W(TS1_W), .TS2_W(TS2_W), .SJW_W(SJW_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tick_i   (tick),
    .fall_i   (fall),
    .idle_i   (bus_idle_i),
    .bit_i    (bit_val),
    .tseg1_i  (tseg1),
    .tseg2_i  (tseg2),
    .sjw_i    (sjw_i),
    .take_o   (take),
    .sample_o (sample_o),
    .txpt_o   (txpt_o)
  );

  assign bit_o = bit_val;

endmodule

// File: rtl/can_bit_timing_chk.sv
module can_bit_timing_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_o,
  input logic sample_o,
  input logic txpt_o
);

  a_r4_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_o && txpt_o));

  a_r3_sample_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |=> !sample_o);

  a_r4_txpt_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    txpt_o |=> !txpt_o);

  a_r5_bit_moves_at_sample: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bit_o) |-> sample_o);

endmodule

bind can_bit_timing can_bit_timing_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bit_o    (bit_o),
  .sample_o (sample_o),
  .txpt_o   (txpt_o)
);

// File: tb/can_bit_timing_tb.sv
module can_bit_timing_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;
  localparam int Q          = 4;      // presc 3 for the edge tests
  localparam int NONE       = 31;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       idle = 1'b0;
  logic [5:0] presc = 6'd3;
  logic [7:0] cfg = {1'b0, 3'd3, 4'd5};
  logic [1:0] sjw = 2'd1;
  logic       bit_o, sample_o, txpt_o;

  int cyc = 0;
  int checks = 0;
  int failures = 0;

  can_bit_timing u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_i       (rx),
    .bus_idle_i (idle),
    .presc_i    (presc),
    .cfg_i      (cfg),
    .sjw_i      (sjw),
    .bit_o      (bit_o),
    .sample_o   (sample_o),
    .txpt_o     (txpt_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (cyc > WD_CYCLES) begin
      failures = failures + 1;
      checks = checks + 1;
      $display("FAIL all watchdog: actual=%0d cycles expected<%0d", cyc, WD_CYCLES);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      failures = failures + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_txpt(output int n);
    do @(negedge clk); while (!txpt_o);
    n = cyc;
  endtask

  task automatic wait_samples(input int k);
    for (int i = 0; i < k; i++) begin
      do @(negedge clk); while (!sample_o);
    end
  endtask

  // nominal timing per configuration (R1, R2, R3)
  typedef struct packed {
    logic [5:0] presc;
    logic [3:0] t1;
    logic [2:0] t2;
    logic [7:0] exp_s;
    logic [7:0] exp_t;
  } cfg_vec_t;

  localparam cfg_vec_t CFG_TBL [4] = '{
    '{6'd3, 4'd5,  3'd3, 8'd28, 8'd44},
    '{6'd0, 4'd2,  3'd1, 8'd4,  8'd6 },
    '{6'd1, 4'd15, 3'd7, 8'd34, 8'd50},
    '{6'd2, 4'd0,  3'd0, 8'd6,  8'd9 }
  };

  // edge stimulus, quanta counted from the sync quantum (Q=4, TSEG1=5, TSEG2=3, SJW=1)
  typedef struct packed {
    logic       idle;
    logic       pre_dom;
    logic [4:0] fall_q;
    logic [4:0] rise_q;
    logic [4:0] fall2_q;
    logic [7:0] exp_s;
    logic [7:0] exp_t;
    logic [3:0] req;
  } edge_vec_t;

  localparam edge_vec_t EDGE_TBL [10] = '{
    '{1'b0, 1'b0, 5'd0,  5'd31, 5'd31, 8'd28, 8'd44, 4'd11}, // in sync: no change
    '{1'b0, 1'b0, 5'd1,  5'd31, 5'd31, 8'd32, 8'd48, 4'd9 }, // late by 1
    '{1'b0, 1'b0, 5'd2,  5'd31, 5'd31, 8'd36, 8'd52, 4'd9 }, // late by 2
    '{1'b0, 1'b0, 5'd4,  5'd31, 5'd31, 8'd36, 8'd52, 4'd9 }, // late by 4, clipped to 2
    '{1'b1, 1'b0, 5'd3,  5'd31, 5'd31, 8'd40, 8'd56, 4'd8 }, // hard sync
    '{1'b0, 1'b0, 5'd8,  5'd31, 5'd31, 8'd64, 8'd36, 4'd10}, // early by 3: cut by 2
    '{1'b0, 1'b0, 5'd9,  5'd31, 5'd31, 8'd64, 8'd80, 4'd10}, // early by 2: new sync
    '{1'b0, 1'b0, 5'd10, 5'd31, 5'd31, 8'd68, 8'd84, 4'd10}, // early by 1: new sync
    '{1'b0, 1'b0, 5'd1,  5'd2,  5'd3,  8'd32, 8'd48, 4'd11}, // second edge ignored
    '{1'b0, 1'b1, 5'd3,  5'd31, 5'd31, 8'd28, 8'd44, 4'd11}  // prior bit dominant
  };

  task automatic samp_case(input logic mode, input int lo_q, input int hi_q,
                           input logic exp, input string req);
    int   n0;
    logic got;
    got = 1'bx;
    cfg = {mode, 3'd3, 4'd5};
    wait_txpt(n0);
    rx = 1'b0;                 // dominant bit so later edges are ignored
    wait_txpt(n0);
    rx = 1'b1;
    for (int rel = 0; rel < 40; rel++) begin
      if (rel > 0) @(negedge clk);
      if (sample_o) got = bit_o;
      if (rel == lo_q*Q + 1) rx = 1'b0;
      if (rel == hi_q*Q + 1) rx = 1'b1;
    end
    chk(req, "sampled bit", int'(got), int'(exp));
    rx = 1'b1;
    wait_samples(2);
  endtask

  initial begin
    int n0, s_rel, t_rel, fall_rel, rise_rel, fall2_rel, tmp;
    edge_vec_t ev;
    cfg_vec_t  cv;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5", "reset bit_o", int'(bit_o), 1);
    chk("R5", "reset sample_o", int'(sample_o), 0);
    chk("R5", "reset txpt_o", int'(txpt_o), 0);

    // R1 / R2 / R3: nominal bit and sample point under several settings
    for (int i = 0; i < 4; i++) begin
      cv = CFG_TBL[i];
      presc = cv.presc;
      cfg = {1'b0, cv.t2, cv.t1};
      for (int k = 0; k < 3; k++) wait_txpt(tmp);
      wait_txpt(n0);
      s_rel = -1; t_rel = -1;
      for (int rel = 1; rel < 120; rel++) begin
        @(negedge clk);
        if (sample_o && s_rel < 0) s_rel = rel;
        if (txpt_o && t_rel < 0) t_rel = rel;
      end
      chk("R3", "sample offset", s_rel, int'(cv.exp_s));
      chk("R1", "bit length", t_rel, int'(cv.exp_t));
    end

    presc = 6'd3;
    cfg = {1'b0, 3'd3, 4'd5};
    wait_samples(3);

    // R8 / R9 / R10 / R11 edge table
    for (int i = 0; i < 10; i++) begin
      ev = EDGE_TBL[i];
      idle = ev.idle;
      fall_rel  = int'(ev.fall_q)  * Q + 1;
      rise_rel  = (ev.rise_q  == NONE) ? 1000 : int'(ev.rise_q)  * Q + 1;
      fall2_rel = (ev.fall2_q == NONE) ? 1000 : int'(ev.fall2_q) * Q + 1;
      if (ev.pre_dom) begin
        wait_txpt(n0);
        rx = 1'b0;
      end
      wait_txpt(n0);
      if (ev.pre_dom) rx = 1'b1;
      s_rel = -1; t_rel = -1;
      for (int rel = 0; rel < 100; rel++) begin
        if (rel > 0) @(negedge clk);
        if (sample_o && s_rel < 0 && rel > fall_rel) s_rel = rel;
        if (txpt_o && t_rel < 0 && rel > 0) t_rel = rel;
        if (rel == fall_rel)  rx = 1'b0;
        if (rel == rise_rel)  rx = 1'b1;
        if (rel == fall2_rel) rx = 1'b0;
      end
      chk($sformatf("R%0d", ev.req), $sformatf("vector %0d sample offset", i),
          s_rel, int'(ev.exp_s));
      chk($sformatf("R%0d", ev.req), $sformatf("vector %0d transmit point", i),
          t_rel, int'(ev.exp_t));
      rx = 1'b1;
      wait_samples(2);
      idle = 1'b0;
    end

    // R6 single sample, R7 majority of three
    samp_case(1'b0, 4, 6, 1'b1, "R6");
    samp_case(1'b1, 4, 6, 1'b0, "R7");
    samp_case(1'b1, 5, 6, 1'b1, "R7");
    samp_case(1'b0, 6, 7, 1'b0, "R6");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule